// File: doc/BRIEF.md
# USB Device Global Interrupt Controller

This block holds the pending flags for the eight device-wide events of a USB device controller. Each flag is raised either by a one-cycle pulse from the USB core or by software. Software can drop any flag and can raise any flag to imitate the event. A per-source enable mask and a per-source priority bit decide which pending flags reach the two interrupt lines, one of low priority and one of high priority. Both lines are level signals driven from flops.

Software reaches the block through a plain 32-bit register port with one write strobe, a byte address and read data that follows the address combinationally. There are five word registers. A read-only status word shows the pending flags. Read/write words hold the enable mask and the priority bits. Two write-only command words drop flags and raise flags, and each bit acts only where a one is written.

Top module: `usb_gint_ctrl`

## Requirements
- R1: Source bits in every register are fixed: 0 bus reset, 1 start of frame, 2 pseudo start of frame, 3 suspend, 4 resume, 5 high-speed status, 6 DMA status change, 7 endpoint 0 setup received. A one-cycle pulse on hw_evt[i] sets pending bit i, and the pending bits read at word offset 0x00.
- R2: Writing the drop word (offset 0x0C) clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R3: Writing the raise word (offset 0x10) sets each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R4: Reads of offsets 0x0C and 0x10 return zero.
- R5: Ones written to data bits 31:8 of any word change no state, and bits 31:8 of every read are zero.
- R6: The priority word (offset 0x08) routes source i to irq_hi when bit i is 1 and to irq_lo when bit i is 0.
- R7: The enable word (offset 0x04) gates the sources. irq_lo is the OR of pending, enabled sources with priority 0, and irq_hi is the same OR over sources with priority 1.
- R8: A hardware pulse on a bit in the same cycle as a drop write of that bit leaves the bit pending.
- R9: Reset clears the pending, enable and priority words, so both lines are low.
- R10: A pending change is readable in the cycle after the clock edge that captures it. The lines follow that change one clock edge later.
- R11: Writes to the status word (offset 0x00) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_evt | input | 8 | One-cycle event pulses from the USB core, one per source |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address, word aligned |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_lo | output | 1 | Low-priority interrupt line |
| irq_hi | output | 1 | High-priority interrupt line |

## Verification
The bound checker checks the following on every cycle. No pending bit rises without a pulse or a raise command. No bit falls without a drop command. Pulses and raise commands always land, including a pulse that meets a drop of the same bit. Each line equals the routed OR of the previous cycle's pending, enable and priority state. Other behaviour only shows up in the bench scenarios: the register address map, zero reads of the command words, the reserved upper data bits, the ignored status write, and the exact cycle in which the status and the lines change. The bench covers these with sweeps over every pending pattern and over 256 enable and priority combinations.

// File: rtl/usb_gint_pkg.sv
package usb_gint_pkg;

    // Word index of each register (byte address bits above the word offset)
    localparam int unsigned IDX_STATUS = 0;
    localparam int unsigned IDX_ENABLE = 1;
    localparam int unsigned IDX_PRIO   = 2;
    localparam int unsigned IDX_DROP   = 3;
    localparam int unsigned IDX_RAISE  = 4;

    // Source positions, shared by every register
    localparam int unsigned SRC_BUS_RESET = 0;
    localparam int unsigned SRC_SOF       = 1;
    localparam int unsigned SRC_PSEUDO_SOF = 2;
    localparam int unsigned SRC_SUSPEND   = 3;
    localparam int unsigned SRC_RESUME    = 4;
    localparam int unsigned SRC_HS_STAT   = 5;
    localparam int unsigned SRC_DMA_CHG   = 6;
    localparam int unsigned SRC_EP0_SETUP = 7;

    typedef enum logic [2:0] {
        SEL_STATUS,
        SEL_ENABLE,
        SEL_PRIO,
        SEL_DROP,
        SEL_RAISE,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/usb_gint_decode.sv
module usb_gint_decode
    import usb_gint_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_SRC-1:0]   pend,
    input  logic [NUM_SRC-1:0]   en,
    input  logic [NUM_SRC-1:0]   prio,
    output logic [NUM_SRC-1:0]   drop_mask,
    output logic [NUM_SRC-1:0]   raise_mask,
    output logic                 en_we,
    output logic                 prio_we,
    output logic [NUM_SRC-1:0]   wr_val,
    output logic [DATA_W-1:0]    rdata
);
    localparam int unsigned WORD_LSB = 2;
    localparam int unsigned SEL_W    = ADDR_W - WORD_LSB;

    logic [SEL_W-1:0] word_idx;
    reg_sel_e         sel;
    logic             unused_bits;

    assign word_idx    = addr[ADDR_W-1:WORD_LSB];
    assign wr_val      = wdata[NUM_SRC-1:0];
    assign unused_bits = ^{wdata[DATA_W-1:NUM_SRC], addr[WORD_LSB-1:0]};

    always_comb begin
        if (word_idx == SEL_W'(IDX_STATUS))      sel = SEL_STATUS;
        else if (word_idx == SEL_W'(IDX_ENABLE)) sel = SEL_ENABLE;
        else if (word_idx == SEL_W'(IDX_PRIO))   sel = SEL_PRIO;
        else if (word_idx == SEL_W'(IDX_DROP))   sel = SEL_DROP;
        else if (word_idx == SEL_W'(IDX_RAISE))  sel = SEL_RAISE;
        else                                     sel = SEL_NONE;
    end

    always_comb begin
        drop_mask  = '0;
        raise_mask = '0;
        en_we      = 1'b0;
        prio_we    = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_DROP:   drop_mask  = wr_val;
                SEL_RAISE:  raise_mask = wr_val;
                SEL_ENABLE: en_we      = 1'b1;
                SEL_PRIO:   prio_we    = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_STATUS: rdata[NUM_SRC-1:0] = pend;
            SEL_ENABLE: rdata[NUM_SRC-1:0] = en;
            SEL_PRIO:   rdata[NUM_SRC-1:0] = prio;
            default: ;
        endcase
    end

endmodule

// File: rtl/usb_gint_cfg.sv
module usb_gint_cfg #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_we,
    input  logic               prio_we,
    input  logic [NUM_SRC-1:0] wr_val,
    output logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] prio
);
    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] prio;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (en_we)   cfg_d.en   = wr_val;
        if (prio_we) cfg_d.prio = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en   = cfg_q.en;
    assign prio = cfg_q.prio;

endmodule

// File: rtl/usb_gint_pend.sv
module usb_gint_pend #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_evt,
    input  logic [NUM_SRC-1:0] drop_mask,
    input  logic [NUM_SRC-1:0] raise_mask,
    output logic [NUM_SRC-1:0] pend
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic bit_d, bit_q;

        // A setting cause always beats a drop in the same cycle
        always_comb begin
            bit_d = bit_q;
            if (drop_mask[i])                 bit_d = 1'b0;
            if (hw_evt[i] || raise_mask[i])   bit_d = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= bit_d;
        end

        assign pend[i] = bit_q;
    end

endmodule

// File: rtl/usb_gint_route.sv
module usb_gint_route #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] prio,
    output logic               irq_lo,
    output logic               irq_hi
);
    typedef struct packed {
        logic lo;
        logic hi;
    } line_t;

    line_t line_d, line_q;
    logic [NUM_SRC-1:0] live;

    always_comb begin
        live      = pend & en;
        line_d.lo = |(live & ~prio);
        line_d.hi = |(live & prio);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign irq_lo = line_q.lo;
    assign irq_hi = line_q.hi;

endmodule

// File: rtl/usb_gint_ctrl.sv
module usb_gint_ctrl #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_evt,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_lo,
    output logic               irq_hi
);
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] prio_q;
    logic [NUM_SRC-1:0] drop_mask;
    logic [NUM_SRC-1:0] raise_mask;
    logic [NUM_SRC-1:0] wr_val;
    logic               en_we;
    logic               prio_we;

    usb_gint_decode #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) decode_i (
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .pend       (pend_q),
        .en         (en_q),
        .prio       (prio_q),
        .drop_mask  (drop_mask),
        .raise_mask (raise_mask),
        .en_we      (en_we),
        .prio_we    (prio_we),
        .wr_val     (wr_val),
        .rdata      (reg_rdata)
    );

    usb_gint_cfg #(
        .NUM_SRC (NUM_SRC)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (en_we),
        .prio_we (prio_we),
        .wr_val  (wr_val),
        .en      (en_q),
        .prio    (prio_q)
    );

    usb_gint_pend #(
        .NUM_SRC (NUM_SRC)
    ) pend_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_evt     (hw_evt),
        .drop_mask  (drop_mask),
        .raise_mask (raise_mask),
        .pend       (pend_q)
    );

    usb_gint_route #(
        .NUM_SRC (NUM_SRC)
    ) route_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend_q),
        .en     (en_q),
        .prio   (prio_q),
        .irq_lo (irq_lo),
        .irq_hi (irq_hi)
    );

endmodule

// File: rtl/usb_gint_ctrl_chk.sv
module usb_gint_ctrl_chk #(
    parameter int unsigned NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] hw_evt,
    input logic [NUM_SRC-1:0] drop_mask,
    input logic [NUM_SRC-1:0] raise_mask,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] en,
    input logic [NUM_SRC-1:0] prio,
    input logic               irq_lo,
    input logic               irq_hi
);
    // R1: every hardware pulse lands in the pending word
    p_evt_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_evt) |=> ((pend & $past(hw_evt)) == $past(hw_evt)));

    // R1/R3: a pending bit only rises from a pulse or a raise command
    p_rise_has_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(hw_evt | raise_mask)) == '0));

    // R2: a pending bit only falls under a drop command
    p_fall_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend) & ~pend & ~$past(drop_mask)) == '0));

    // R3: a raise command lands
    p_raise_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|raise_mask) |=> ((pend & $past(raise_mask)) == $past(raise_mask)));

    // R8: pulse meeting a drop of the same bit survives
    p_evt_beats_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_evt & drop_mask)) |=>
            ((pend & $past(hw_evt & drop_mask)) == $past(hw_evt & drop_mask)));

    // R6/R7/R10: low line follows last cycle's routed state
    p_lo_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo == $past(|(pend & en & ~prio)));

    // R6/R7/R10: high line follows last cycle's routed state
    p_hi_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi == $past(|(pend & en & prio)));

    // R9: state is clear as reset releases
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend == '0 && en == '0 && prio == '0 && !irq_lo && !irq_hi));

endmodule

bind usb_gint_ctrl usb_gint_ctrl_chk #(
    .NUM_SRC (NUM_SRC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_evt     (hw_evt),
    .drop_mask  (drop_mask),
    .raise_mask (raise_mask),
    .pend       (pend_q),
    .en         (en_q),
    .prio       (prio_q),
    .irq_lo     (irq_lo),
    .irq_hi     (irq_hi)
);

// File: tb/usb_gint_ctrl_tb_top.sv
`timescale 1ns/1ps
module usb_gint_ctrl_tb_top;
    localparam logic [4:0] A_STATUS = 5'h00;
    localparam logic [4:0] A_ENABLE = 5'h04;
    localparam logic [4:0] A_PRIO   = 5'h08;
    localparam logic [4:0] A_DROP   = 5'h0C;
    localparam logic [4:0] A_RAISE  = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  hw_evt = '0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_lo, irq_hi;

    int unsigned errors = 0;
    int unsigned checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    usb_gint_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_evt    (hw_evt),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_lo    (irq_lo),
        .irq_hi    (irq_hi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write lands on the posedge between two negedges; returns on the later negedge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R9: reset state
        rd(A_STATUS, r); chk("R9 status", r, 0);
        rd(A_ENABLE, r); chk("R9 enable", r, 0);
        rd(A_PRIO, r);   chk("R9 prio", r, 0);
        chk("R9 lines", {30'd0, irq_hi, irq_lo}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // R1: each pulse sets its own bit; R2 drop clears it
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); hw_evt = 8'(1 << i);
            @(negedge clk); hw_evt = '0;
            rd(A_STATUS, r); chk("R1 pulse sets bit", r, 32'(1 << i));
            wr(A_DROP, 32'(1 << i));
            rd(A_STATUS, r); chk("R2 drop clears bit", r, 0);
        end

        // R3/R2/R4/R5: every pending pattern through the command words
        for (int p = 0; p < 256; p++) begin
            wr(A_RAISE, 32'hFFFF_FF00 | 32'(p));
            rd(A_STATUS, r); chk("R3 R5 raise pattern", r, 32'(p));
            wr(A_RAISE, 32'hFFFF_FF00);
            rd(A_STATUS, r); chk("R3 zero bits keep", r, 32'(p));
            rd(A_RAISE, r);  chk("R4 raise reads zero", r, 0);
            rd(A_DROP, r);   chk("R4 drop reads zero", r, 0);
            wr(A_DROP, 32'hFFFF_FF00 | 32'(p & 8'h0F));
            rd(A_STATUS, r); chk("R2 R5 partial drop", r, 32'(p & 8'hF0));
            wr(A_DROP, 32'h0000_00FF);
            rd(A_STATUS, r); chk("R2 full drop", r, 0);
        end

        // R5: reserved bits of config words
        wr(A_ENABLE, 32'hFFFF_FFFF);
        rd(A_ENABLE, r); chk("R5 enable upper zero", r, 32'h0000_00FF);
        wr(A_PRIO, 32'hA5A5_A53C);
        rd(A_PRIO, r);   chk("R5 prio upper zero", r, 32'h0000_003C);

        // R11: status word ignores writes
        wr(A_RAISE, 32'h0000_0011);
        wr(A_STATUS, 32'hFFFF_FFEE);
        rd(A_STATUS, r); chk("R11 status write ignored", r, 32'h0000_0011);
        wr(A_DROP, 32'hFF);

        // R10: timing of status and line, source 3 on low line
        wr(A_ENABLE, 32'hFF);
        wr(A_PRIO, 32'h00);
        settle();
        @(negedge clk); hw_evt = 8'h08;
        @(negedge clk); hw_evt = '0;
        rd(A_STATUS, r); chk("R10 status next cycle", r, 32'h08);
        chk("R10 line not yet", {31'd0, irq_lo}, 0);
        @(negedge clk);
        chk("R10 line one edge later", {31'd0, irq_lo}, 1);
        wr(A_DROP, 32'h08);
        chk("R10 line holds one edge after drop", {31'd0, irq_lo}, 1);
        @(negedge clk);
        chk("R10 line falls", {31'd0, irq_lo}, 0);

        // R8: pulse and drop of same bit in one cycle, bit pending and not pending
        wr(A_RAISE, 32'h20);
        @(negedge clk);
        hw_evt = 8'h20; reg_wr_en = 1'b1; reg_addr = A_DROP; reg_wdata = 32'h21;
        @(negedge clk);
        hw_evt = '0; reg_wr_en = 1'b0; reg_wdata = '0;
        rd(A_STATUS, r); chk("R8 pulse beats drop (was set)", r, 32'h20);
        wr(A_DROP, 32'hFF);
        @(negedge clk);
        hw_evt = 8'h80; reg_wr_en = 1'b1; reg_addr = A_DROP; reg_wdata = 32'h80;
        @(negedge clk);
        hw_evt = '0; reg_wr_en = 1'b0; reg_wdata = '0;
        rd(A_STATUS, r); chk("R8 pulse beats drop (was clear)", r, 32'h80);
        wr(A_DROP, 32'hFF);

        // R6/R7: routing sweep over enable, priority and pending
        for (int k = 0; k < 256; k++) begin
            logic [7:0] e, pr, pd;
            logic       exp_lo, exp_hi;
            e  = 8'(k);
            pr = 8'(k * 37) ^ 8'h5A;
            pd = ~8'(k) ^ 8'(k << 1);
            wr(A_ENABLE, 32'(e));
            wr(A_PRIO, 32'(pr));
            wr(A_DROP, 32'hFF);
            wr(A_RAISE, 32'(pd));
            settle();
            exp_lo = |(pd & e & ~pr);
            exp_hi = |(pd & e & pr);
            chk("R7 low line", {31'd0, irq_lo}, {31'd0, exp_lo});
            chk("R6 high line", {31'd0, irq_hi}, {31'd0, exp_hi});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule